// File: doc/BRIEF.md
# ECC Partial Write Merge Unit

This block sits between a single requester and a memory word store of 72 bits: 64 data bits and 8 check bits. It accepts one request at a time, either a read or a write with per-byte enables. Check-bit protection is chosen per request by `ecc_en_i`. With protection off, a write of any width goes straight to the store as a byte-masked write. With protection on, a full eight-byte write is encoded and written at once. A narrower write becomes a read-modify-write: the old word is read, checked and corrected, the new bytes are merged in under the byte enables, the check bits are recomputed, and the whole word is written back.

Reads also pass through the checker. They return corrected data and single-bit or multi-bit status. A separate error output repeats that status only when reporting is enabled. The store side is a simple request port that always accepts. For reads it returns data with `mem_rvalid_i` one cycle after the read request.

Top module: `ecc_rmw_unit`

## Requirements
- R1: While and after reset, `busy_o`, `mem_req_o`, `rsp_valid_o`, `sbe_o`, `mbe_o` and `err_o` are low.
- R2: A protected word stores data in bits [63:0] and check bits in [71:64]. Data bits 0..63 take, in order, the Hamming positions 3, 5, 6, 7, 9, ... (every integer from 3 up that is not a power of two). Check bit i (i < 7) is the parity of the data bits whose position has bit i set. Check bit 7 is the parity of all 64 data bits and check bits 0..6. A read of such a word returns its data with no status flags.
- R3: A protected write with all eight byte enables issues no read and exactly one store write with all nine lane enables set (`mem_mask_o` = 9'h1FF). `busy_o` is high for 1 cycle after the accepting edge.
- R4: An unprotected write issues no read and exactly one store write with `mem_mask_o` = {1'b0, byte enables}. It leaves the check byte and the unselected data bytes unchanged. `busy_o` is high for 1 cycle.
- R5: A protected write with some byte enables clear issues one read, then one full nine-lane write. The written word holds the new bytes where enabled and the old bytes elsewhere, with freshly computed check bits. `busy_o` is high for 3 cycles.
- R6: A single flipped bit anywhere in the 72-bit word is corrected. The corrected data is returned on a read, or used as the old bytes in a merge, and `sbe_o` pulses while `mbe_o` stays low.
- R7: Two flipped bits give an `mbe_o` pulse with `sbe_o` low, and the raw data is left uncorrected. A partial write still completes using the raw old bytes and fresh check bits.
- R8: `err_o` pulses together with `sbe_o` or `mbe_o` only when `err_rep_en_i` was high at acceptance. `sbe_o` and `mbe_o` are not gated by it.
- R9: A read drives `rsp_valid_o` high for one cycle, at the third rising edge after acceptance. Status flags pulse in the same cycle. An unprotected read returns the raw stored data with no flags.
- R10: A request presented while `busy_o` is high is ignored and causes no store access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request present; accepted when not busy |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Word address |
| req_wdata_i | input | 64 | Write data |
| req_be_i | input | 8 | Byte enables for writes |
| ecc_en_i | input | 1 | Check-bit protection for this request |
| err_rep_en_i | input | 1 | Enable `err_o` for this request |
| busy_o | output | 1 | Request in progress |
| rsp_valid_o | output | 1 | Read data valid pulse |
| rsp_rdata_o | output | 64 | Read data (corrected when protected) |
| sbe_o | output | 1 | Corrected single-bit error pulse |
| mbe_o | output | 1 | Uncorrectable error pulse |
| err_o | output | 1 | Gated error pulse |
| mem_req_o | output | 1 | Store access |
| mem_we_o | output | 1 | Store access is a write |
| mem_addr_o | output | ADDR_W | Store address |
| mem_wdata_o | output | 72 | Store write word |
| mem_mask_o | output | 9 | Lane enables; bit 8 = check byte |
| mem_rvalid_i | input | 1 | Store read data valid |
| mem_rdata_i | input | 72 | Store read word |

## Verification
After the accepting edge, a direct write holds `busy_o` for one cycle, a read for two and a read-modify-write for three. A read response and every status pulse land on the third rising edge. The store update from a merge lands on the fourth. Each request task counts the busy cycles and compares them with these figures. It then samples responses, flag pulses and store contents at the falling edge after `busy_o` drops, so every result is read only once it is due.

// File: rtl/ecc_rmw_pkg.sv
package ecc_rmw_pkg;
  localparam int DATA_W  = 64;
  localparam int HAM_W   = 7;
  localparam int CHK_W   = HAM_W + 1;
  localparam int WORD_W  = DATA_W + CHK_W;
  localparam int BYTES   = DATA_W / 8;
  localparam int LANES   = WORD_W / 8;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_READ,
    ST_CHECK,
    ST_WRITE
  } rmw_state_e;

  // Hamming position of data bit j: j-th integer >= 3 that is not a power of two
  function automatic int ham_pos(input int j);
    int p;
    int n;
    p = 2;
    n = -1;
    while (n < j) begin
      p++;
      if ((p & (p - 1)) != 0) n++;
    end
    return p;
  endfunction

  function automatic logic [DATA_W-1:0] chk_mask(input int i);
    logic [DATA_W-1:0] m;
    m = '0;
    for (int j = 0; j < DATA_W; j++) m[j] = ((ham_pos(j) >> i) & 1) != 0;
    return m;
  endfunction

  localparam int MAX_POS = ham_pos(DATA_W - 1);
endpackage

// File: rtl/ecc_secded_enc.sv
module ecc_secded_enc
  import ecc_rmw_pkg::*;
(
  input  logic [DATA_W-1:0] data_i,
  output logic [CHK_W-1:0]  chk_o
);
  logic [HAM_W-1:0] ham;

  for (genvar i = 0; i < HAM_W; i++) begin : g_chk
    localparam logic [DATA_W-1:0] MASK = chk_mask(i);
    assign ham[i] = ^(data_i & MASK);
  end

  assign chk_o = {^{data_i, ham}, ham};
endmodule

// File: rtl/ecc_secded_dec.sv
module ecc_secded_dec
  import ecc_rmw_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  output logic [DATA_W-1:0] data_o,
  output logic              sbe_o,
  output logic              mbe_o
);
  logic [CHK_W-1:0]  recalc;
  logic [HAM_W-1:0]  syn;
  logic [DATA_W-1:0] flip;
  logic              par_err;
  logic              syn_oob;

  ecc_secded_enc u_enc (
    .data_i (word_i[DATA_W-1:0]),
    .chk_o  (recalc)
  );

  assign syn     = recalc[HAM_W-1:0] ^ word_i[DATA_W +: HAM_W];
  assign par_err = ^word_i;
  assign syn_oob = syn > HAM_W'(MAX_POS);

  for (genvar j = 0; j < DATA_W; j++) begin : g_flip
    localparam logic [HAM_W-1:0] POS = HAM_W'(ham_pos(j));
    assign flip[j] = par_err && (syn == POS);
  end

  assign data_o = word_i[DATA_W-1:0] ^ flip;
  // odd weight with a legal syndrome -> one bit; even weight with nonzero syndrome -> two
  assign sbe_o  = par_err && !syn_oob;
  assign mbe_o  = (!par_err && (syn != '0)) || (par_err && syn_oob);
endmodule

// File: rtl/ecc_byte_merge.sv
module ecc_byte_merge #(
  parameter int NBYTES = 8,
  localparam int W     = NBYTES * 8
) (
  input  logic [W-1:0]      old_i,
  input  logic [W-1:0]      new_i,
  input  logic [NBYTES-1:0] be_i,
  output logic [W-1:0]      merged_o
);
  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    assign merged_o[b*8 +: 8] = be_i[b] ? new_i[b*8 +: 8] : old_i[b*8 +: 8];
  end
endmodule

// File: rtl/ecc_rmw_unit.sv
module ecc_rmw_unit
  import ecc_rmw_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic [BYTES-1:0]  req_be_i,
  input  logic              ecc_en_i,
  input  logic              err_rep_en_i,
  output logic              busy_o,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic              sbe_o,
  output logic              mbe_o,
  output logic              err_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [WORD_W-1:0] mem_wdata_o,
  output logic [LANES-1:0]  mem_mask_o,
  input  logic              mem_rvalid_i,
  input  logic [WORD_W-1:0] mem_rdata_i
);
  rmw_state_e        state_q, state_d;
  logic              wr_q, ecc_q, rep_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [BYTES-1:0]  be_q;
  logic              rsp_valid_q, sbe_q, mbe_q, err_q;
  logic [DATA_W-1:0] rsp_rdata_q;

  logic              accept, direct;
  logic [DATA_W-1:0] dec_data, old_data, merged;
  logic              dec_sbe, dec_mbe, flag_sbe, flag_mbe;
  logic [CHK_W-1:0]  wr_chk;

  assign accept = (state_q == ST_IDLE) && req_valid_i;
  assign direct = req_write_i && (!ecc_en_i || (&req_be_i));

  ecc_secded_dec u_dec (
    .word_i (mem_rdata_i),
    .data_o (dec_data),
    .sbe_o  (dec_sbe),
    .mbe_o  (dec_mbe)
  );

  assign old_data = ecc_q ? dec_data : mem_rdata_i[DATA_W-1:0];
  assign flag_sbe = ecc_q && dec_sbe;
  assign flag_mbe = ecc_q && dec_mbe;

  ecc_byte_merge #(.NBYTES(BYTES)) u_merge (
    .old_i    (old_data),
    .new_i    (wdata_q),
    .be_i     (be_q),
    .merged_o (merged)
  );

  ecc_secded_enc u_enc (
    .data_i (wdata_q),
    .chk_o  (wr_chk)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (accept) state_d = direct ? ST_WRITE : ST_READ;
      ST_READ:  state_d = ST_CHECK;
      ST_CHECK: if (mem_rvalid_i) state_d = wr_q ? ST_WRITE : ST_IDLE;
      ST_WRITE: state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      wr_q        <= 1'b0;
      ecc_q       <= 1'b0;
      rep_q       <= 1'b0;
      addr_q      <= '0;
      wdata_q     <= '0;
      be_q        <= '0;
      rsp_valid_q <= 1'b0;
      rsp_rdata_q <= '0;
      sbe_q       <= 1'b0;
      mbe_q       <= 1'b0;
      err_q       <= 1'b0;
    end else begin
      state_q     <= state_d;
      rsp_valid_q <= 1'b0;
      sbe_q       <= 1'b0;
      mbe_q       <= 1'b0;
      err_q       <= 1'b0;
      if (accept) begin
        wr_q    <= req_write_i;
        ecc_q   <= ecc_en_i;
        rep_q   <= err_rep_en_i;
        addr_q  <= req_addr_i;
        wdata_q <= req_wdata_i;
        be_q    <= req_be_i;
      end
      if (state_q == ST_CHECK && mem_rvalid_i) begin
        sbe_q <= flag_sbe;
        mbe_q <= flag_mbe;
        err_q <= rep_q && (flag_sbe || flag_mbe);
        if (wr_q) begin
          wdata_q <= merged;
        end else begin
          rsp_valid_q <= 1'b1;
          rsp_rdata_q <= old_data;
        end
      end
    end
  end

  assign busy_o      = state_q != ST_IDLE;
  assign mem_req_o   = (state_q == ST_READ) || (state_q == ST_WRITE);
  assign mem_we_o    = state_q == ST_WRITE;
  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = {ecc_q ? wr_chk : '0, wdata_q};
  assign mem_mask_o  = ecc_q ? '1 : {1'b0, be_q};
  assign rsp_valid_o = rsp_valid_q;
  assign rsp_rdata_o = rsp_rdata_q;
  assign sbe_o       = sbe_q;
  assign mbe_o       = mbe_q;
  assign err_o       = err_q;

  assert_full_lanes_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o && ecc_q |-> (&mem_mask_o));
  assert_chk_lane_off_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o && !ecc_q |-> !mem_mask_o[LANES-1]);
  assert_flags_excl_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sbe_o && mbe_o));
  assert_err_gated_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (sbe_o || mbe_o));
  assert_rsp_after_data_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> $past(mem_rvalid_i));
  assert_write_ends_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o |=> !busy_o);
  assert_busy_holds_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(mem_addr_o));
endmodule

// File: tb/ecc_rmw_unit_bench.sv
`timescale 1ns/1ps
module ecc_rmw_unit_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        req_valid = 0, req_write = 0, ecc_en = 0, rep_en = 0;
  logic [15:0] req_addr = '0;
  logic [63:0] req_wdata = '0;
  logic [7:0]  req_be = '0;
  logic        busy, rsp_valid, sbe, mbe, err;
  logic [63:0] rsp_rdata;
  logic        mem_req, mem_we;
  logic [15:0] mem_addr;
  logic [71:0] mem_wdata;
  logic [8:0]  mem_mask;
  logic        mem_rvalid = 0;
  logic [71:0] mem_rdata = '0;

  ecc_rmw_unit u_ecc_rmw_unit (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata), .req_be_i(req_be), .ecc_en_i(ecc_en),
    .err_rep_en_i(rep_en), .busy_o(busy), .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata),
    .sbe_o(sbe), .mbe_o(mbe), .err_o(err), .mem_req_o(mem_req), .mem_we_o(mem_we),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_mask_o(mem_mask),
    .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata)
  );

  logic [71:0] mem [16];
  logic        inj_req = 0;
  logic [3:0]  inj_addr = '0;
  logic [71:0] inj_mask = '0;
  int n_rd = 0, n_wr = 0, n_rsp = 0, n_sbe = 0, n_mbe = 0, n_err = 0;
  logic [8:0]  last_mask = '0;
  logic [63:0] last_rsp = '0;

  always @(posedge clk) begin
    mem_rvalid <= 1'b0;
    if (inj_req) mem[inj_addr] <= mem[inj_addr] ^ inj_mask;
    if (mem_req) begin
      if (mem_we) begin
        for (int b = 0; b < 9; b++)
          if (mem_mask[b]) mem[mem_addr[3:0]][b*8 +: 8] <= mem_wdata[b*8 +: 8];
        n_wr <= n_wr + 1;
        last_mask <= mem_mask;
      end else begin
        mem_rdata  <= mem[mem_addr[3:0]];
        mem_rvalid <= 1'b1;
        n_rd <= n_rd + 1;
      end
    end
  end

  always @(negedge clk) begin
    if (rsp_valid) begin n_rsp++; last_rsp = rsp_rdata; end
    if (sbe) n_sbe++;
    if (mbe) n_mbe++;
    if (err) n_err++;
  end

  int tests = 0, fails = 0;
  int cyc, d_rd, d_wr, d_rsp, d_sbe, d_mbe, d_err;

  task automatic check(input bit ok, input string r, input logic [71:0] act, input logic [71:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  function automatic logic [7:0] ref_chk(input logic [63:0] d);
    logic [7:0] c;
    int p;
    c = '0;
    p = 2;
    for (int j = 0; j < 64; j++) begin
      p++;
      while ((p & (p - 1)) == 0) p++;
      for (int i = 0; i < 7; i++) if (p[i]) c[i] ^= d[j];
    end
    c[7] = ^{d, c[6:0]};
    return c;
  endfunction

  function automatic logic [63:0] ref_merge(input logic [63:0] o, input logic [63:0] n, input logic [7:0] be);
    logic [63:0] m;
    for (int b = 0; b < 8; b++) m[b*8 +: 8] = be[b] ? n[b*8 +: 8] : o[b*8 +: 8];
    return m;
  endfunction

  task automatic op(input logic w, input logic [3:0] a, input logic [63:0] d,
                    input logic [7:0] be, input logic e, input logic rp);
    int s_rd, s_wr, s_rsp, s_sbe, s_mbe, s_err;
    @(negedge clk);
    s_rd = n_rd; s_wr = n_wr; s_rsp = n_rsp; s_sbe = n_sbe; s_mbe = n_mbe; s_err = n_err;
    req_write = w; req_addr = {12'h0, a}; req_wdata = d; req_be = be; ecc_en = e; rep_en = rp;
    req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    cyc = 0;
    while (busy && cyc < 50) begin cyc++; @(negedge clk); end
    #1;
    d_rd = n_rd - s_rd; d_wr = n_wr - s_wr; d_rsp = n_rsp - s_rsp;
    d_sbe = n_sbe - s_sbe; d_mbe = n_mbe - s_mbe; d_err = n_err - s_err;
  endtask

  task automatic inject(input logic [3:0] a, input logic [71:0] m);
    @(negedge clk);
    inj_addr = a; inj_mask = m; inj_req = 1'b1;
    @(negedge clk);
    inj_req = 1'b0;
  endtask

  task automatic summary;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [63:0] dA, dB, m, corrupt;
    logic [63:0] shadow [16];
    int bits [8];
    void'($urandom(32'h5eed_0042));
    for (int i = 0; i < 16; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(!busy && !mem_req && !rsp_valid && !sbe && !mbe && !err, "R1 in reset",
          {busy, mem_req, rsp_valid, sbe, mbe, err}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!busy && !mem_req && !rsp_valid && !err, "R1 after reset", {busy, mem_req, rsp_valid, err}, 0);

    // R3 full protected write, R2 layout
    dA = 64'h0123_4567_89ab_cdef;
    op(1, 1, dA, 8'hFF, 1, 1);
    check(cyc == 1 && d_rd == 0 && d_wr == 1, "R3 direct write timing", {cyc[7:0], d_rd[7:0], d_wr[7:0]}, {8'd1, 8'd0, 8'd1});
    check(last_mask == 9'h1FF, "R3 lanes", last_mask, 9'h1FF);
    check(mem[1] == {ref_chk(dA), dA}, "R2 stored word", mem[1], {ref_chk(dA), dA});

    // R9 read timing, R2 clean read
    op(0, 1, '0, 8'h00, 1, 1);
    check(cyc == 2 && d_rsp == 1 && d_rd == 1 && d_wr == 0, "R9 read timing", {cyc[7:0], d_rsp[7:0]}, {8'd2, 8'd1});
    check(last_rsp == dA && d_sbe == 0 && d_mbe == 0, "R2 clean read", {d_sbe[3:0], d_mbe[3:0], last_rsp}, {8'h0, dA});

    // R5 partial protected write
    dB = 64'hfedc_ba98_7654_3210;
    op(1, 1, dB, 8'h0F, 1, 1);
    m = ref_merge(dA, dB, 8'h0F);
    check(cyc == 3 && d_rd == 1 && d_wr == 1 && last_mask == 9'h1FF, "R5 rmw sequence",
          {cyc[7:0], d_rd[7:0], d_wr[7:0], last_mask}, {8'd3, 8'd1, 8'd1, 9'h1FF});
    check(mem[1] == {ref_chk(m), m}, "R5 merged word", mem[1], {ref_chk(m), m});

    // R4 unprotected partial write
    op(1, 2, dA, 8'hFF, 1, 1);
    op(1, 2, dB, 8'hA5, 0, 1);
    m = ref_merge(dA, dB, 8'hA5);
    check(cyc == 1 && d_rd == 0 && last_mask == 9'h0A5, "R4 masked write", {cyc[7:0], d_rd[7:0], last_mask}, {8'd1, 8'd0, 9'h0A5});
    check(mem[2] == {ref_chk(dA), m}, "R4 check byte kept", mem[2], {ref_chk(dA), m});

    // R6 single-bit correction at edge and random positions
    bits = '{0, 7, 63, 64, 70, 71, 0, 0};
    bits[6] = $urandom_range(0, 71);
    bits[7] = $urandom_range(0, 71);
    foreach (bits[k]) begin
      op(1, 3, dB ^ 64'(k), 8'hFF, 1, 1);
      inject(3, 72'(1) << bits[k]);
      op(0, 3, '0, 8'h00, 1, 1);
      check(last_rsp == (dB ^ 64'(k)) && d_sbe == 1 && d_mbe == 0, "R6 single corrected",
            {d_sbe[3:0], d_mbe[3:0], last_rsp}, {8'h10, dB ^ 64'(k)});
      check(d_err == 1, "R8 err on sbe", d_err, 1);
    end

    // R7 double-bit detection on read
    op(1, 4, dA, 8'hFF, 1, 1);
    inject(4, (72'(1) << 5) | (72'(1) << 40));
    corrupt = dA ^ ((64'(1) << 5) | (64'(1) << 40));
    op(0, 4, '0, 8'h00, 1, 1);
    check(d_mbe == 1 && d_sbe == 0 && last_rsp == corrupt, "R7 double detect",
          {d_sbe[3:0], d_mbe[3:0], last_rsp}, {8'h01, corrupt});
    // R8 reporting disabled
    op(0, 4, '0, 8'h00, 1, 0);
    check(d_err == 0 && d_mbe == 1, "R8 err gated", {d_err[3:0], d_mbe[3:0]}, 8'h01);

    // R7 partial write over a double error
    op(1, 4, dB, 8'hF0, 1, 1);
    m = ref_merge(corrupt, dB, 8'hF0);
    check(d_mbe == 1 && d_wr == 1 && mem[4] == {ref_chk(m), m}, "R7 rmw completes", mem[4], {ref_chk(m), m});

    // R6 partial write over a single error
    op(1, 5, dA, 8'hFF, 1, 1);
    inject(5, 72'(1) << 33);
    op(1, 5, dB, 8'h3C, 1, 1);
    m = ref_merge(dA, dB, 8'h3C);
    check(d_sbe == 1 && mem[5] == {ref_chk(m), m}, "R6 corrected merge", mem[5], {ref_chk(m), m});

    // R9 unprotected read returns raw data
    op(1, 6, dA, 8'hFF, 1, 1);
    inject(6, 72'(1) << 9);
    op(0, 6, '0, 8'h00, 0, 1);
    check(last_rsp == (dA ^ (64'(1) << 9)) && d_sbe == 0 && d_mbe == 0 && d_err == 0, "R9 raw read",
          last_rsp, dA ^ (64'(1) << 9));

    // R10 requests during busy are ignored
    op(1, 7, dA, 8'hFF, 1, 1);
    op(1, 8, dA, 8'hFF, 1, 1);
    begin
      int s_wr, s_rd;
      @(negedge clk);
      s_wr = n_wr; s_rd = n_rd;
      req_write = 1; req_addr = 16'd7; req_wdata = dB; req_be = 8'h01; ecc_en = 1; req_valid = 1;
      @(posedge clk);
      @(negedge clk);
      req_addr = 16'd8; req_be = 8'hFF; ecc_en = 0;
      @(negedge clk);
      @(negedge clk);
      req_valid = 0;
      while (busy) @(negedge clk);
      #1;
      check(mem[8] == {ref_chk(dA), dA}, "R10 busy request ignored", mem[8], {ref_chk(dA), dA});
      check(n_wr - s_wr == 1 && n_rd - s_rd == 1, "R10 access count", {n_wr - s_wr, n_rd - s_rd}, {32'd1, 32'd1});
    end

    // random protected traffic against a shadow model
    for (int i = 0; i < 16; i++) begin
      shadow[i] = {$urandom, $urandom};
      op(1, 4'(i), shadow[i], 8'hFF, 1, 1);
    end
    for (int n = 0; n < 60; n++) begin
      logic [3:0]  a;
      logic [7:0]  be;
      logic [63:0] d;
      a = 4'($urandom_range(0, 15));
      be = 8'($urandom);
      d = {$urandom, $urandom};
      case ($urandom_range(0, 2))
        0: begin
          op(0, a, '0, 8'h00, 1, 1);
          check(last_rsp == shadow[a] && d_sbe == 0 && d_mbe == 0 && cyc == 2, "R9 random read", last_rsp, shadow[a]);
        end
        1: begin
          op(1, a, d, 8'hFF, 1, 1);
          shadow[a] = d;
          check(cyc == 1 && mem[a] == {ref_chk(d), d}, "R3 random full write", mem[a], {ref_chk(d), d});
        end
        default: begin
          if (be == 8'hFF) be = 8'h7F;
          op(1, a, d, be, 1, 1);
          shadow[a] = ref_merge(shadow[a], d, be);
          check(cyc == 3 && mem[a] == {ref_chk(shadow[a]), shadow[a]}, "R5 random merge",
                mem[a], {ref_chk(shadow[a]), shadow[a]});
        end
      endcase
    end
    summary();
  end
endmodule